// File: doc/BRIEF.md
# Calibration code update pulse controller

This block turns register writes and a periodic tick into single-cycle ready strobes for four analog compensation targets. The four targets are the current reference, the transmitter, the receive termination and the receive variable-gain stage. Each strobe tells its target to latch the compensation code that is already stored. Software has two manual paths. The broadcast path strobes all four targets at once and starts no recompute. The override path first asks an external code engine to recompute one selected target, waits for the engine's done handshake, and then strobes only that target.

Automatic updates come from a periodic tick. Each target has a periodic enable and a power-state qualifier. When the qualifier is set, a tick reaches the target only while the target's data path is in a low-power state. Both manual request bits act on a rising edge. Each must be written back to 0 before it can produce another pulse. When a manual pulse and an automatic update land on the same target in the same cycle, they produce one shared strobe.

Register access uses a one-bit opcode: 0 reads and 1 writes. A read returns its data on the cycle after the request. The low 12 bits of the register are writable. The upper bits are fixed.

Top module: `rcal_pulse_ctrl`

## Requirements
- R1: After reset, a read returns 0x00008001 (bit 0 set, bit 15 fixed at 1, all other bits 0), `rdy_strobe` is 0 and `eng_req` is 0.
- R2: A write (opcode 1) stores `acc_wdata[11:0]` and ignores bits 31:12, which always read as 0x00008 in the upper 20 bits. A read (opcode 0) presents the register on `acc_rdata` one cycle after the request.
- R3: A rising edge of register bit 11 (broadcast) drives `rdy_strobe` to 4'b1111 for exactly one cycle, two clock edges after the write is presented. It does not raise `eng_req`.
- R4: While bit 11 or bit 8 stays at 1, further writes of 1 to that bit produce no further pulse. A new pulse needs the bit to be written to 0 first.
- R5: A rising edge of bit 8 (override) raises `eng_req` one cycle after the register update. `eng_sel` equals bits 10:9 at that moment. Both stay unchanged until `eng_done` is seen, and `eng_req` drops on the edge that accepts `eng_done`.
- R6: The override strobe is one-hot on `rdy_strobe`, for one cycle, on the cycle after `eng_done` is accepted. The index comes from the selector: 0 is current reference, 1 is transmit, 2 is receive termination, 3 is receive gain stage. `rdy_strobe` uses the same index order.
- R7: A rising edge of bit 8 that arrives while a recompute is outstanding is dropped. It causes no later request and no strobe.
- R8: A `per_tick` pulse sets `rdy_strobe` on the next cycle for each target whose periodic enable is 1 and whose qualifier is 0. The periodic enables are register bit 0 (current reference), bit 1 (transmit), bit 2 (receive gain stage) and bit 3 (receive termination).
- R9: The qualifiers are bits 4 (current reference), 5 (transmit), 6 (receive gain stage) and 7 (receive termination). A target with its qualifier set updates on a tick only while it is in a low-power state.
  - Transmit counts as low-power when `tx_pstate` is not 0.
  - Both receive targets count as low-power when `rx_pstate` is not 0.
  - The current reference counts as low-power only when both state inputs are 2 or 3.
  - State codes: 0 = active, 1 = standby, 2 = partial, 3 = slumber.
- R10: A manual strobe and an automatic update that fall on the same cycle merge into one strobe of one cycle. This holds for both the broadcast and the override path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calibration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access request |
| acc_op | input | 1 | Access opcode: 0 read, 1 write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_pstate | input | 2 | Transmit power state (0 active, 1 standby, 2 partial, 3 slumber) |
| rx_pstate | input | 2 | Receive power state, same coding |
| per_tick | input | 1 | Periodic update tick, one cycle wide |
| eng_req | output | 1 | Recompute request to the code engine |
| eng_sel | output | 2 | Target being recomputed |
| eng_done | input | 1 | Recompute finished |
| rdy_strobe | output | 4 | One-cycle ready strobe per target |

## Verification
The main function is driven with several patterns:
- broadcast writes, which separate the all-target path from the one-hot override path;
- override writes with each selector value, which catch a wrong index mapping;
- ticks under enable masks of alternating bits, which show whether the two swapped receive enable and qualifier positions are routed correctly.

Several stimuli probe the arming logic. Held request bits, and requests arriving while a recompute is outstanding, check that each rising edge is honoured once and only when the block is ready for it. Ticks under every combination of the power states check the qualifier, including the rule that the current reference needs both paths in partial or slumber. Finally, manual pulses are placed on the same cycle as ticks, to show that the two sources merge into a single one-cycle strobe.

// File: rtl/rcal_pkg.sv
// Shared definitions for the calibration strobe controller.
// Assumes a 12-bit writable control field; the upper part of the
// 32-bit word is a fixed constant.
package rcal_pkg;
    localparam int NTGT   = 4;
    localparam int TGT_W  = $clog2(NTGT);
    localparam int CTRL_W = 12;

    // Target index order used on strobes and on the selector.
    typedef enum logic [1:0] {
        TGT_IREF   = 2'd0,
        TGT_TX     = 2'd1,
        TGT_RXTERM = 2'd2,
        TGT_RXVGA  = 2'd3
    } tgt_e;

    // Power state coding of each data path.
    typedef enum logic [1:0] {
        PS_ON   = 2'd0,
        PS_STBY = 2'd1,
        PS_PART = 2'd2,
        PS_SLMB = 2'd3
    } pstate_e;

    // Writable control field, MSB first.
    typedef struct packed {
        logic       bcast;   // bit 11
        logic [1:0] sel;     // bits 10:9
        logic       ovr;     // bit 8
        logic [3:0] qual;    // bits 7:4, register order
        logic [3:0] per;     // bits 3:0, register order
    } ctrl_t;
endpackage

// File: rtl/rcal_ctrl_regs.sv
// Control register with a one-bit opcode access port.
// Writes take the low CTRL_W bits; reads return the word one cycle later.
// Assumes only one access per cycle.
module rcal_ctrl_regs
    import rcal_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter logic [CTRL_W-1:0] CTRL_RST = 12'h001,
    parameter logic [DATA_W-CTRL_W-1:0] FIXED_HI = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_op,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output ctrl_t             ctrl
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wdata_unused;

    assign wdata_unused = ^acc_wdata[DATA_W-1:CTRL_W];

    // Store the writable field on a write access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (acc_en && acc_op)
            ctrl_q <= acc_wdata[CTRL_W-1:0];
    end

    // Capture the full word on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (acc_en && !acc_op)
            rdata_q <= {FIXED_HI, ctrl_q};
    end

    assign acc_rdata = rdata_q;
    assign ctrl      = ctrl_t'(ctrl_q);

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_op) |=> (ctrl_q == $past(acc_wdata[CTRL_W-1:0])));
    // R2
    rd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_op) |=> (acc_rdata == {FIXED_HI, $past(ctrl_q)}));
endmodule

// File: rtl/rcal_edge_arm.sv
// Rising-edge detector for a software request bit.
// Fires for one cycle when the bit is 1 and was 0 in the previous cycle;
// re-arms only after the bit has been seen at 0.
module rcal_edge_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fire
);
    logic seen_q;

    // Remember the request level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else
            seen_q <= lvl;
    end

    assign fire = lvl && !seen_q;

    // R4
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/rcal_ovr_seq.sv
// Override sequencer: on a start while idle, requests a recompute of the
// selected target, holds the request until the engine reports done, then
// issues a one-hot done vector for one cycle. A start while busy is dropped.
module rcal_ovr_seq
    import rcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TGT_W-1:0] sel_in,
    input  logic             eng_done,
    output logic             eng_req,
    output logic [TGT_W-1:0] eng_sel,
    output logic [NTGT-1:0]  done_vec
);
    logic             busy_q;
    logic [TGT_W-1:0] sel_q;
    logic             finish;

    assign finish = busy_q && eng_done;

    // Track the outstanding recompute and the target it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sel_q  <= '0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            sel_q  <= sel_in;
        end else if (finish) begin
            busy_q <= 1'b0;
        end
    end

    // Decode the finished target into a one-hot vector.
    generate
        for (genvar i = 0; i < NTGT; i++) begin : g_dec
            assign done_vec[i] = finish && (sel_q == TGT_W'(i));
        end
    endgenerate

    assign eng_req = busy_q;
    assign eng_sel = sel_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_sel)));
    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> !eng_req);
    // R6
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done && start) |=> $stable(eng_sel));
endmodule

// File: rtl/rcal_auto_gate.sv
// Periodic update gate: for each target, passes the tick when the periodic
// enable is set and, if the qualifier is set, the target's path is in a
// low-power state. Inputs are in target index order.
module rcal_auto_gate
    import rcal_pkg::*;
(
    input  logic            per_tick,
    input  logic [NTGT-1:0] per_en,
    input  logic [NTGT-1:0] qual_en,
    input  logic [1:0]      tx_pstate,
    input  logic [1:0]      rx_pstate,
    output logic [NTGT-1:0] upd_vec
);
    logic            tx_deep;
    logic            rx_deep;
    logic [NTGT-1:0] in_low;

    // Classify the path power states for each target.
    always_comb begin
        tx_deep = (tx_pstate == PS_PART) || (tx_pstate == PS_SLMB);
        rx_deep = (rx_pstate == PS_PART) || (rx_pstate == PS_SLMB);
        in_low             = '0;
        in_low[TGT_IREF]   = tx_deep && rx_deep;
        in_low[TGT_TX]     = (tx_pstate != PS_ON);
        in_low[TGT_RXTERM] = (rx_pstate != PS_ON);
        in_low[TGT_RXVGA]  = (rx_pstate != PS_ON);
    end

    // One gate per target.
    generate
        for (genvar i = 0; i < NTGT; i++) begin : g_gate
            assign upd_vec[i] = per_tick && per_en[i] && (!qual_en[i] || in_low[i]);
        end
    endgenerate
endmodule

// File: rtl/rcal_pulse_ctrl.sv
// Calibration code update pulse controller (top).
// Merges broadcast, override and periodic sources into one registered
// one-cycle strobe per target. Assumes per_tick is a one-cycle pulse.
module rcal_pulse_ctrl
    import rcal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_op,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [1:0]        tx_pstate,
    input  logic [1:0]        rx_pstate,
    input  logic              per_tick,
    output logic              eng_req,
    output logic [TGT_W-1:0]  eng_sel,
    input  logic              eng_done,
    output logic [NTGT-1:0]   rdy_strobe
);
    ctrl_t           ctrl;
    logic            bcast_fire;
    logic            ovr_fire;
    logic [NTGT-1:0] ovr_vec;
    logic [NTGT-1:0] auto_vec;
    logic [NTGT-1:0] per_t;
    logic [NTGT-1:0] qual_t;
    logic [NTGT-1:0] strobe_q;

    rcal_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_op    (acc_op),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .ctrl      (ctrl)
    );

    rcal_edge_arm u_bcast_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ctrl.bcast),
        .fire  (bcast_fire)
    );

    rcal_edge_arm u_ovr_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ctrl.ovr),
        .fire  (ovr_fire)
    );

    rcal_ovr_seq u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ovr_fire),
        .sel_in   (ctrl.sel),
        .eng_done (eng_done),
        .eng_req  (eng_req),
        .eng_sel  (eng_sel),
        .done_vec (ovr_vec)
    );

    // Reorder register fields (rx gain stage before rx termination) into target order.
    always_comb begin
        per_t              = '0;
        qual_t             = '0;
        per_t[TGT_IREF]    = ctrl.per[0];
        per_t[TGT_TX]      = ctrl.per[1];
        per_t[TGT_RXVGA]   = ctrl.per[2];
        per_t[TGT_RXTERM]  = ctrl.per[3];
        qual_t[TGT_IREF]   = ctrl.qual[0];
        qual_t[TGT_TX]     = ctrl.qual[1];
        qual_t[TGT_RXVGA]  = ctrl.qual[2];
        qual_t[TGT_RXTERM] = ctrl.qual[3];
    end

    rcal_auto_gate u_auto (
        .per_tick  (per_tick),
        .per_en    (per_t),
        .qual_en   (qual_t),
        .tx_pstate (tx_pstate),
        .rx_pstate (rx_pstate),
        .upd_vec   (auto_vec)
    );

    // Merge all sources into one registered strobe per target.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= '0;
        else
            strobe_q <= ({NTGT{bcast_fire}} | ovr_vec | auto_vec);
    end

    assign rdy_strobe = strobe_q;

    // R3
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_fire |=> (rdy_strobe == {NTGT{1'b1}}));
    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bcast_fire && ovr_vec == '0 && !per_tick) |=> (rdy_strobe == '0));
    // R8
    auto_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> ((rdy_strobe & $past(per_t & ~qual_t)) == $past(per_t & ~qual_t)));
    // R6
    ovr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> rdy_strobe[$past(eng_sel)]);
endmodule

// File: tb/rcal_pulse_ctrl_test.sv
module rcal_pulse_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_op = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  tx_pstate = 2'd0;
    logic [1:0]  rx_pstate = 2'd0;
    logic        per_tick = 1'b0;
    logic        eng_req;
    logic [1:0]  eng_sel;
    logic        eng_done = 1'b0;
    logic [3:0]  rdy_strobe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int         at;
        logic [3:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    rcal_pulse_ctrl uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_op(acc_op),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .tx_pstate(tx_pstate), .rx_pstate(rx_pstate), .per_tick(per_tick),
        .eng_req(eng_req), .eng_sel(eng_sel), .eng_done(eng_done),
        .rdy_strobe(rdy_strobe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input logic [3:0] v, input string tag);
        sb.push_back('{at, v, tag});
    endtask

    task automatic wr(input logic [31:0] d, output int c);
        c = cyc;
        acc_en = 1'b1; acc_op = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_op = 1'b0;
    endtask

    task automatic rd(output logic [31:0] d);
        acc_en = 1'b1; acc_op = 1'b0;
        @(negedge clk);
        acc_en = 1'b0;
        d = acc_rdata;
    endtask

    task automatic tick(output int c);
        c = cyc;
        per_tick = 1'b1;
        @(negedge clk);
        per_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: compare each cycle's strobe with the scoreboard head.
    always @(negedge clk) begin
        logic [3:0] e;
        string t;
        e = 4'h0;
        t = "R4 unexpected strobe";
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].at == cyc) begin
                e = sb[0].val;
                t = sb[0].tag;
                void'(sb.pop_front());
            end
            if (e != 4'h0 || rdy_strobe != 4'h0)
                chk(rdy_strobe == e, t, 32'(rdy_strobe), 32'(e));
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int c;
        int d;
        logic [31:0] rv;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(rdy_strobe == 4'h0, "R1 strobe", 32'(rdy_strobe), 0);
        chk(eng_req == 1'b0, "R1 eng_req", 32'(eng_req), 0);
        rd(rv);
        chk(rv == 32'h0000_8001, "R1 reset word", rv, 32'h0000_8001);

        // R2 write masks upper bits; read latency one cycle
        wr(32'hFFFF_F0F6, c);
        rd(rv);
        chk(rv == 32'h0000_80F6, "R2 readback", rv, 32'h0000_80F6);
        wr(32'h0, c);
        rd(rv);
        chk(rv == 32'h0000_8000, "R2 cleared", rv, 32'h0000_8000);

        // R3 broadcast
        wr(32'h800, c);
        push(c + 2, 4'hF, "R3 broadcast");
        idle(1);
        chk(eng_req == 1'b0, "R3 no recompute", 32'(eng_req), 0);
        idle(1);
        chk(rdy_strobe == 4'h0, "R3 one cycle", 32'(rdy_strobe), 0);

        // R4 held bit gives no pulse, re-arm after clear
        wr(32'h800, c);
        idle(4);
        wr(32'h0, c);
        wr(32'h800, c);
        push(c + 2, 4'hF, "R4 rearmed broadcast");
        idle(3);
        wr(32'h0, c);
        idle(2);

        // R5 / R6 override for each selector value
        for (int s = 0; s < 4; s++) begin
            wr((32'(s) << 9) | 32'h100, c);
            idle(1);
            chk(eng_req == 1'b1, "R5 request raised", 32'(eng_req), 1);
            chk(eng_sel == 2'(s), "R5 selector", 32'(eng_sel), 32'(s));
            idle(3);
            chk(eng_req == 1'b1, "R5 request held", 32'(eng_req), 1);
            eng_done = 1'b1;
            d = cyc;
            push(d + 1, 4'(1 << s), "R6 override strobe");
            @(negedge clk);
            eng_done = 1'b0;
            chk(eng_req == 1'b0, "R5 request dropped", 32'(eng_req), 0);
            wr(32'h0, c);
            idle(2);
        end

        // R7 new override while busy is dropped; R4 held override bit
        wr(32'h100, c);
        idle(1);
        wr(32'h0, c);
        wr(32'h300, c);
        idle(2);
        chk(eng_sel == 2'd0, "R7 selector kept", 32'(eng_sel), 0);
        eng_done = 1'b1;
        push(cyc + 1, 4'b0001, "R7 first override only");
        @(negedge clk);
        eng_done = 1'b0;
        idle(4);
        chk(eng_req == 1'b0, "R7 no second request", 32'(eng_req), 0);
        wr(32'h0, c);
        idle(2);

        // R8 periodic enables, register bit order 0 iref,1 tx,2 rxvga,3 rxterm
        wr(32'h005, c);
        tick(c);
        push(c + 1, 4'b1001, "R8 iref+rxvga");
        idle(2);
        wr(32'h00A, c);
        tick(c);
        push(c + 1, 4'b0110, "R8 tx+rxterm");
        idle(2);
        wr(32'h000, c);
        tick(c);
        idle(2);
        chk(rdy_strobe == 4'h0, "R8 disabled", 32'(rdy_strobe), 0);

        // R9 qualifiers
        wr(32'h0FF, c);
        tx_pstate = 2'd0; rx_pstate = 2'd0;
        tick(c);
        idle(2);
        tx_pstate = 2'd1; rx_pstate = 2'd0;
        tick(c);
        push(c + 1, 4'b0010, "R9 tx standby");
        idle(2);
        tx_pstate = 2'd2; rx_pstate = 2'd3;
        tick(c);
        push(c + 1, 4'b1111, "R9 all deep");
        idle(2);
        tx_pstate = 2'd1; rx_pstate = 2'd2;
        tick(c);
        push(c + 1, 4'b1110, "R9 iref needs both deep");
        idle(2);
        wr(32'h05F, c);
        tx_pstate = 2'd0; rx_pstate = 2'd0;
        tick(c);
        push(c + 1, 4'b0110, "R9 partial qualifiers");
        idle(2);
        tx_pstate = 2'd2; rx_pstate = 2'd2;
        tick(c);
        push(c + 1, 4'b1111, "R9 partial qualifiers deep");
        idle(2);
        tx_pstate = 2'd0; rx_pstate = 2'd0;

        // R10 merge broadcast with tick
        wr(32'h001, c);
        wr(32'h801, c);
        push(c + 2, 4'hF, "R10 broadcast merge");
        tick(d);
        idle(1);
        chk(rdy_strobe == 4'h0, "R10 single cycle", 32'(rdy_strobe), 0);
        wr(32'h001, c);
        idle(1);

        // R10 merge override with tick on same target
        wr(32'h101, c);
        idle(2);
        eng_done = 1'b1;
        per_tick = 1'b1;
        push(cyc + 1, 4'b0001, "R10 override merge");
        @(negedge clk);
        eng_done = 1'b0;
        per_tick = 1'b0;
        idle(1);
        chk(rdy_strobe == 4'h0, "R10 override single", 32'(rdy_strobe), 0);
        wr(32'h0, c);
        idle(3);

        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s actual=missing expected=%h", sb[0].tag, sb[0].val);
        end
        summary();
        $finish;
    end
endmodule